// File: doc/BRIEF.md
# Tagged AXI4 SRAM

This block is an AXI4 subordinate that stores 64-bit words in a single-port data array. Beside that array it keeps a one-bit tag array that holds one flag for each 16-byte aligned slot. A master marks a 16-byte value as a valid capability by writing it as one aligned two-beat burst with the write user bit high on both beats. The read user bit returns the slot's flag on every beat. Any other store that touches the slot clears the flag. Reads narrower than a word never report a set flag.

Requests enter three shallow FIFOs, one each for write addresses, write data and read addresses. A single engine serves one burst at a time through the one RAM port. When a write and a read are both waiting, the write goes first. A burst that would reach past the configured size is answered with SLVERR on every beat and changes no memory. A burst that uses any type other than incrementing gets the same answer. The deployed size is 128 KiB, which puts the last word at 0x1FFF8 and the last slot at 0x1FFF0. The default parameter value is smaller so that elaboration stays cheap. The memory contents, tags included, are undefined until they are written.

Top module: `tsram_axi`

## Requirements
- R1: Every B response carries the ID of its write address, and every R beat carries the ID of its read address.
- R2: A read of length L returns L+1 beats with rlast high only on the last beat, and rid and rresp stay constant across the burst. A write whose wlast disagrees with its beat count is answered with SLVERR.
- R3: A write stores only the byte lanes whose wstrb bit is 1, and a later read returns the merged word.
- R4: A slot's tag becomes 1 only when a single INCR burst of two 8-byte beats starts at an address with bits [3:0] equal to 0 and carries wuser=1 and a full strobe on both beats. If wuser is 1 on only one of the two beats, the tag is 0.
- R5: A single-beat write with wuser=1 leaves the tag at 0, even when both halves of the slot are written by two such bursts.
- R6: A two-beat burst with wuser=1 that starts at bits [3:0] equal to 8 leaves both slots it touches with tag 0.
- R7: A write of any kind other than R4 to either half of a tagged slot clears that slot's tag. This includes a write with a partial strobe.
- R8: Each read beat returns on ruser the tag of the slot holding its word. One burst may mix tagged and untagged slots, and clearing one slot leaves its neighbour's tag unchanged.
- R9: A read with arsize below 3 (narrower than 8 bytes) returns ruser=0, even from a tagged slot.
- R10: A burst whose last byte lies at or beyond the configured size gets SLVERR (resp code 2'b10) on B or on every R beat. It writes nothing, and its read beats carry rdata=0 and ruser=0. Bursts that end exactly at the top are answered OKAY (2'b00).
- R11: While rready or bready is low, the pending response and its fields hold steady. When the write-address FIFO is full, awready goes low.
- R12: When a write address and a read address are both waiting at an idle point, the write is served first.
- R13: After reset, awready, wready and arready are 1 and rvalid and bvalid are 0. A reset in the middle of a burst drops that burst, and the next request is served normally.
- R14: A burst type other than INCR (awburst/arburst not equal to 2'b01) is answered with SLVERR and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low reset |
| s_awid | input | ID_W | Write address ID |
| s_awaddr | input | ADDR_W | Write start byte address |
| s_awlen | input | 8 | Write beats minus one |
| s_awsize | input | 3 | Write beat size code |
| s_awburst | input | 2 | Write burst type |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address FIFO has room |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte enables |
| s_wlast | input | 1 | Final write beat |
| s_wuser | input | 1 | Tag bit for this beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data FIFO has room |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Master accepts write response |
| s_arid | input | ID_W | Read address ID |
| s_araddr | input | ADDR_W | Read start byte address |
| s_arlen | input | 8 | Read beats minus one |
| s_arsize | input | 3 | Read beat size code |
| s_arburst | input | 2 | Read burst type |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address FIFO has room |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rlast | output | 1 | Final read beat |
| s_ruser | output | 1 | Tag bit for this beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Master accepts read beat |

## Verification
The properties watch the response side on every cycle. They check that held responses stay stable under backpressure, that rid and rresp stay constant inside a read burst, that error beats never carry data or a tag, and that B and R are never offered together. Whether a tag is right depends on the history of earlier bursts to the same slot. The bench therefore has to show the tag rules through its scenarios: aligned and misaligned capability bursts, split halves, partial strobes, narrow reads, and neighbouring slots. The bench also shows the range boundary, write-first ordering, FIFO fill and reset in the middle of a burst.

// File: rtl/tsram_pkg.sv
package tsram_pkg;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
   localparam logic [1:0] BURST_INCR  = 2'b01;
   localparam logic [2:0] SIZE_WORD   = 3'd3;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_WBEAT = 2'd1,
      ENG_WRESP = 2'd2,
      ENG_RBEAT = 2'd3
   } eng_state_e;
endpackage

// File: rtl/tsram_fifo.sv
module tsram_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic             full,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("tsram_fifo: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] hold_q;
      logic             vld_q;
      always_ff @(posedge clk) begin
         if (push && !vld_q) hold_q <= din;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= (vld_q & ~pop) | push;
      end
      assign full  = vld_q;
      assign empty = !vld_q;
      assign dout  = hold_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [WIDTH-1:0] slot_q [DEPTH];
      logic [PW-1:0]    wp_q, rp_q;
      logic [PW:0]      cnt_q;
      logic             do_push, do_pop;

      assign do_push = push && !full;
      assign do_pop  = pop && !empty;

      always_ff @(posedge clk) begin
         if (do_push) slot_q[wp_q] <= din;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end
      assign full  = (cnt_q == (PW+1)'(DEPTH));
      assign empty = (cnt_q == '0);
      assign dout  = slot_q[rp_q];
   end
endmodule

// File: rtl/tsram_store.sv
module tsram_store #(
   parameter int DATA_W = 64,
   parameter int WORDS  = 2048
) (
   input  logic                       clk,
   input  logic [$clog2(WORDS)-1:0]   idx,
   input  logic                       we,
   input  logic [DATA_W/8-1:0]        be,
   input  logic [DATA_W-1:0]          wd,
   input  logic                       tag_we,
   input  logic                       tag_wd,
   output logic [DATA_W-1:0]          rd,
   output logic                       tag_rd
);
   localparam int IDX_W = $clog2(WORDS);
   localparam int SLOTS = WORDS / 2;
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] word_arr [WORDS];
   logic              flag_arr [SLOTS];
   logic [IDX_W-2:0]  slot_idx;

   assign slot_idx = idx[IDX_W-1:1];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LANES; l++) begin
            if (be[l]) word_arr[idx][l*8 +: 8] <= wd[l*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (tag_we) flag_arr[slot_idx] <= tag_wd;
   end

   assign rd     = word_arr[idx];
   assign tag_rd = flag_arr[slot_idx];
endmodule

// File: rtl/tsram_engine.sv
module tsram_engine
   import tsram_pkg::*;
#(
   parameter int ID_W      = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int MEM_BYTES = 16384
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ID_W-1:0]                 aw_id,
   input  logic [ADDR_W-1:0]               aw_addr,
   input  logic [7:0]                      aw_len,
   input  logic [2:0]                      aw_size,
   input  logic [1:0]                      aw_burst,
   input  logic                            aw_empty,
   output logic                            aw_pop,
   input  logic [DATA_W-1:0]               w_data,
   input  logic [DATA_W/8-1:0]             w_strb,
   input  logic                            w_last,
   input  logic                            w_user,
   input  logic                            w_empty,
   output logic                            w_pop,
   input  logic [ID_W-1:0]                 ar_id,
   input  logic [ADDR_W-1:0]               ar_addr,
   input  logic [7:0]                      ar_len,
   input  logic [2:0]                      ar_size,
   input  logic [1:0]                      ar_burst,
   input  logic                            ar_empty,
   output logic                            ar_pop,
   output logic [ID_W-1:0]                 b_id,
   output logic [1:0]                      b_resp,
   output logic                            b_valid,
   input  logic                            b_ready,
   output logic [ID_W-1:0]                 r_id,
   output logic [DATA_W-1:0]               r_data,
   output logic [1:0]                      r_resp,
   output logic                            r_last,
   output logic                            r_user,
   output logic                            r_valid,
   input  logic                            r_ready,
   output logic [$clog2(MEM_BYTES/8)-1:0]  ram_idx,
   output logic                            ram_we,
   output logic [DATA_W/8-1:0]             ram_be,
   output logic [DATA_W-1:0]               ram_wd,
   output logic                            tag_we,
   output logic                            tag_wd,
   input  logic [DATA_W-1:0]               ram_rd,
   input  logic                            tag_rd
);
   localparam int IDX_W  = $clog2(MEM_BYTES/8);
   localparam int LOC_W  = IDX_W + 3;
   localparam int SPAN_W = ADDR_W + 17;

   function automatic logic req_bad(input logic [ADDR_W-1:0] a, input logic [7:0] l,
                                    input logic [2:0] s, input logic [1:0] b);
      logic [SPAN_W-1:0] nbytes, span;
      nbytes = SPAN_W'({1'b0, l} + 9'd1) << s;
      span   = SPAN_W'(a) + nbytes;
      return (b != BURST_INCR) || (s > SIZE_WORD) || (span > SPAN_W'(MEM_BYTES));
   endfunction

   eng_state_e       st_q;
   logic [ID_W-1:0]  id_q;
   logic [LOC_W-1:0] addr_q;
   logic [7:0]       len_q, cnt_q;
   logic [2:0]       size_q;
   logic             err_q, cap_q, half_ok_q, lastbad_q;

   logic             take_w, take_r, final_beat, sel_bad, sel_cap;
   logic [ID_W-1:0]  sel_id;
   logic [ADDR_W-1:0] sel_addr;
   logic [7:0]       sel_len;
   logic [2:0]       sel_size;
   logic [1:0]       sel_burst;
   logic [LOC_W-1:0] step;

   assign take_w     = (st_q == ENG_IDLE) && !aw_empty;
   assign take_r     = (st_q == ENG_IDLE) && aw_empty && !ar_empty;
   assign sel_id     = take_w ? aw_id    : ar_id;
   assign sel_addr   = take_w ? aw_addr  : ar_addr;
   assign sel_len    = take_w ? aw_len   : ar_len;
   assign sel_size   = take_w ? aw_size  : ar_size;
   assign sel_burst  = take_w ? aw_burst : ar_burst;
   assign sel_bad    = req_bad(sel_addr, sel_len, sel_size, sel_burst);
   assign sel_cap    = (sel_len == 8'd1) && (sel_size == SIZE_WORD) &&
                       (sel_addr[3:0] == 4'd0) && (sel_burst == BURST_INCR);
   assign step       = LOC_W'(1) << size_q;
   assign final_beat = (cnt_q == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ENG_IDLE;
         id_q      <= '0;
         addr_q    <= '0;
         len_q     <= '0;
         cnt_q     <= '0;
         size_q    <= '0;
         err_q     <= 1'b0;
         cap_q     <= 1'b0;
         half_ok_q <= 1'b0;
         lastbad_q <= 1'b0;
      end else begin
         case (st_q)
            ENG_IDLE: begin
               if (take_w || take_r) begin
                  id_q      <= sel_id;
                  addr_q    <= sel_addr[LOC_W-1:0];
                  len_q     <= sel_len;
                  size_q    <= sel_size;
                  cnt_q     <= '0;
                  err_q     <= sel_bad;
                  cap_q     <= sel_cap && !sel_bad;
                  half_ok_q <= 1'b0;
                  lastbad_q <= 1'b0;
                  st_q      <= take_w ? ENG_WBEAT : ENG_RBEAT;
               end
            end
            ENG_WBEAT: begin
               if (!w_empty) begin
                  cnt_q  <= cnt_q + 1'b1;
                  addr_q <= addr_q + step;
                  if (cnt_q == 8'd0) half_ok_q <= w_user && (&w_strb);
                  if (w_last != final_beat) lastbad_q <= 1'b1;
                  if (final_beat) st_q <= ENG_WRESP;
               end
            end
            ENG_WRESP: begin
               if (b_ready) st_q <= ENG_IDLE;
            end
            default: begin
               if (r_ready) begin
                  cnt_q  <= cnt_q + 1'b1;
                  addr_q <= addr_q + step;
                  if (final_beat) st_q <= ENG_IDLE;
               end
            end
         endcase
      end
   end

   always_comb begin
      aw_pop  = take_w;
      ar_pop  = take_r;
      w_pop   = (st_q == ENG_WBEAT) && !w_empty;
      ram_idx = addr_q[LOC_W-1:3];
      ram_we  = w_pop && !err_q;
      ram_be  = w_strb;
      ram_wd  = w_data;
      tag_we  = ram_we;
      tag_wd  = cap_q && (cnt_q == 8'd1) && half_ok_q && w_user && (&w_strb) &&
                w_last && !lastbad_q;
      b_valid = (st_q == ENG_WRESP);
      b_id    = id_q;
      b_resp  = (err_q || lastbad_q) ? RESP_SLVERR : RESP_OKAY;
      r_valid = (st_q == ENG_RBEAT);
      r_id    = id_q;
      r_resp  = err_q ? RESP_SLVERR : RESP_OKAY;
      r_data  = err_q ? '0 : ram_rd;
      r_user  = !err_q && (size_q == SIZE_WORD) && tag_rd;
      r_last  = final_beat;
   end
endmodule

// File: rtl/tsram_axi.sv
module tsram_axi
   import tsram_pkg::*;
#(
   parameter int ID_W       = 4,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int MEM_BYTES  = 16384,
   parameter int FIFO_DEPTH = 2
) (
   input  logic                  aclk,
   input  logic                  aresetn,
   input  logic [ID_W-1:0]       s_awid,
   input  logic [ADDR_W-1:0]     s_awaddr,
   input  logic [7:0]            s_awlen,
   input  logic [2:0]            s_awsize,
   input  logic [1:0]            s_awburst,
   input  logic                  s_awvalid,
   output logic                  s_awready,
   input  logic [DATA_W-1:0]     s_wdata,
   input  logic [DATA_W/8-1:0]   s_wstrb,
   input  logic                  s_wlast,
   input  logic                  s_wuser,
   input  logic                  s_wvalid,
   output logic                  s_wready,
   output logic [ID_W-1:0]       s_bid,
   output logic [1:0]            s_bresp,
   output logic                  s_bvalid,
   input  logic                  s_bready,
   input  logic [ID_W-1:0]       s_arid,
   input  logic [ADDR_W-1:0]     s_araddr,
   input  logic [7:0]            s_arlen,
   input  logic [2:0]            s_arsize,
   input  logic [1:0]            s_arburst,
   input  logic                  s_arvalid,
   output logic                  s_arready,
   output logic [ID_W-1:0]       s_rid,
   output logic [DATA_W-1:0]     s_rdata,
   output logic [1:0]            s_rresp,
   output logic                  s_rlast,
   output logic                  s_ruser,
   output logic                  s_rvalid,
   input  logic                  s_rready
);
   localparam int WORDS  = MEM_BYTES / 8;
   localparam int IDX_W  = $clog2(WORDS);
   localparam int STRB_W = DATA_W / 8;
   localparam int A_W    = ID_W + ADDR_W + 8 + 3 + 2;
   localparam int W_W    = DATA_W + STRB_W + 2;

   if (DATA_W != 64) begin : g_bad_width
      $error("tsram_axi: DATA_W must be 64");
   end
   if ((MEM_BYTES % 16 != 0) || (MEM_BYTES < 32) || ((1 << IDX_W) != WORDS)) begin : g_bad_size
      $error("tsram_axi: MEM_BYTES must be a power of two of at least 32");
   end

   logic [A_W-1:0] aw_q, ar_q;
   logic [W_W-1:0] w_q;
   logic aw_full, aw_empty, aw_pop, w_full, w_empty, w_pop, ar_full, ar_empty, ar_pop;

   logic [ID_W-1:0]   aw_id, ar_id;
   logic [ADDR_W-1:0] aw_addr, ar_addr;
   logic [7:0]        aw_len, ar_len;
   logic [2:0]        aw_size, ar_size;
   logic [1:0]        aw_burst, ar_burst;
   logic [DATA_W-1:0] w_data;
   logic [STRB_W-1:0] w_strb;
   logic              w_last, w_user;

   logic [IDX_W-1:0]  ram_idx;
   logic              ram_we, tag_we, tag_wd, tag_rd;
   logic [STRB_W-1:0] ram_be;
   logic [DATA_W-1:0] ram_wd, ram_rd;

   assign s_awready = !aw_full;
   assign s_wready  = !w_full;
   assign s_arready = !ar_full;

   tsram_fifo #(.WIDTH(A_W), .DEPTH(FIFO_DEPTH)) u_aw_fifo (
      .clk(aclk), .rst_n(aresetn), .push(s_awvalid && !aw_full),
      .din({s_awid, s_awaddr, s_awlen, s_awsize, s_awburst}),
      .full(aw_full), .pop(aw_pop), .dout(aw_q), .empty(aw_empty));

   tsram_fifo #(.WIDTH(W_W), .DEPTH(FIFO_DEPTH)) u_w_fifo (
      .clk(aclk), .rst_n(aresetn), .push(s_wvalid && !w_full),
      .din({s_wdata, s_wstrb, s_wlast, s_wuser}),
      .full(w_full), .pop(w_pop), .dout(w_q), .empty(w_empty));

   tsram_fifo #(.WIDTH(A_W), .DEPTH(FIFO_DEPTH)) u_ar_fifo (
      .clk(aclk), .rst_n(aresetn), .push(s_arvalid && !ar_full),
      .din({s_arid, s_araddr, s_arlen, s_arsize, s_arburst}),
      .full(ar_full), .pop(ar_pop), .dout(ar_q), .empty(ar_empty));

   assign {aw_id, aw_addr, aw_len, aw_size, aw_burst} = aw_q;
   assign {ar_id, ar_addr, ar_len, ar_size, ar_burst} = ar_q;
   assign {w_data, w_strb, w_last, w_user}            = w_q;

   tsram_engine #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_engine (
      .clk(aclk), .rst_n(aresetn),
      .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size),
      .aw_burst(aw_burst), .aw_empty(aw_empty), .aw_pop(aw_pop),
      .w_data(w_data), .w_strb(w_strb), .w_last(w_last), .w_user(w_user),
      .w_empty(w_empty), .w_pop(w_pop),
      .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
      .ar_burst(ar_burst), .ar_empty(ar_empty), .ar_pop(ar_pop),
      .b_id(s_bid), .b_resp(s_bresp), .b_valid(s_bvalid), .b_ready(s_bready),
      .r_id(s_rid), .r_data(s_rdata), .r_resp(s_rresp), .r_last(s_rlast),
      .r_user(s_ruser), .r_valid(s_rvalid), .r_ready(s_rready),
      .ram_idx(ram_idx), .ram_we(ram_we), .ram_be(ram_be), .ram_wd(ram_wd),
      .tag_we(tag_we), .tag_wd(tag_wd), .ram_rd(ram_rd), .tag_rd(tag_rd));

   tsram_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
      .clk(aclk), .idx(ram_idx), .we(ram_we), .be(ram_be), .wd(ram_wd),
      .tag_we(tag_we), .tag_wd(tag_wd), .rd(ram_rd), .tag_rd(tag_rd));
endmodule

// File: rtl/tsram_axi_chk.sv
module tsram_axi_chk #(
   parameter int ID_W   = 4,
   parameter int DATA_W = 64
) (
   input logic              aclk,
   input logic              aresetn,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic [ID_W-1:0]   s_rid,
   input logic [1:0]        s_rresp,
   input logic              s_rlast,
   input logic              s_ruser,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic [ID_W-1:0]   s_bid,
   input logic [1:0]        s_bresp
);
   // R11
   r_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rid) &&
                                $stable(s_rlast) && $stable(s_ruser) && $stable(s_rresp));

   // R11
   b_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      s_bvalid && !s_bready |=> s_bvalid && $stable(s_bid) && $stable(s_bresp));

   // R2
   r_burst_cont_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      s_rvalid && s_rready && !s_rlast |=> s_rvalid && (s_rid == $past(s_rid)) &&
                                           (s_rresp == $past(s_rresp)));

   // R10
   err_beat_clean_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      s_rvalid && (s_rresp != 2'b00) |-> !s_ruser && (s_rdata == '0));

   // R12
   one_resp_chk: assert property (@(posedge aclk) disable iff (!aresetn)
      $onehot0({s_rvalid, s_bvalid}));
endmodule

bind tsram_axi tsram_axi_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
   .aclk(aclk), .aresetn(aresetn),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rid(s_rid),
   .s_rresp(s_rresp), .s_rlast(s_rlast), .s_ruser(s_ruser),
   .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp));

// File: tb/tsram_axi_bench.sv
`timescale 1ns/100ps
module tsram_axi_bench;
   localparam int NV = 27;

   typedef struct packed {
      logic        op;
      logic [1:0]  burst;
      logic [31:0] addr;
      logic [7:0]  len;
      logic [2:0]  size;
      logic [7:0]  strb;
      logic [3:0]  usr;
      logic [63:0] dat;
      logic [1:0]  xresp;
      logic [3:0]  xusr;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'b01, 32'h100,  8'd1, 3'd3, 8'hFF, 4'b0011, 64'hA000, 2'b00, 4'b0000}, // R4
      '{1'b1, 2'b01, 32'h100,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0011}, // R4
      '{1'b0, 2'b01, 32'h110,  8'd0, 3'd3, 8'hFF, 4'b0001, 64'hB000, 2'b00, 4'b0000}, // R5
      '{1'b0, 2'b01, 32'h118,  8'd0, 3'd3, 8'hFF, 4'b0001, 64'hC000, 2'b00, 4'b0000}, // R5
      '{1'b1, 2'b01, 32'h110,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}, // R5
      '{1'b0, 2'b01, 32'h128,  8'd1, 3'd3, 8'hFF, 4'b0011, 64'hD000, 2'b00, 4'b0000}, // R6
      '{1'b1, 2'b01, 32'h128,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}, // R6
      '{1'b0, 2'b01, 32'h200,  8'd1, 3'd3, 8'hFF, 4'b0011, 64'hE000, 2'b00, 4'b0000}, // R7
      '{1'b0, 2'b01, 32'h208,  8'd0, 3'd3, 8'h0F, 4'b0000, 64'hF000, 2'b00, 4'b0000}, // R7
      '{1'b1, 2'b01, 32'h200,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}, // R7
      '{1'b0, 2'b01, 32'h300,  8'd1, 3'd3, 8'hFF, 4'b0011, 64'h1100, 2'b00, 4'b0000}, // R8
      '{1'b0, 2'b01, 32'h310,  8'd1, 3'd3, 8'hFF, 4'b0011, 64'h1200, 2'b00, 4'b0000}, // R8
      '{1'b0, 2'b01, 32'h318,  8'd0, 3'd3, 8'hFF, 4'b0000, 64'h1300, 2'b00, 4'b0000}, // R8
      '{1'b1, 2'b01, 32'h300,  8'd3, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0011}, // R8
      '{1'b1, 2'b01, 32'h300,  8'd0, 3'd2, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}, // R9
      '{1'b0, 2'b01, 32'h3FF0, 8'd1, 3'd3, 8'hFF, 4'b0011, 64'h2000, 2'b00, 4'b0000}, // R10
      '{1'b1, 2'b01, 32'h3FF8, 8'd0, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0001}, // R10
      '{1'b0, 2'b01, 32'h3FF8, 8'd1, 3'd3, 8'hFF, 4'b0011, 64'h2100, 2'b10, 4'b0000}, // R10
      '{1'b1, 2'b01, 32'h3FF0, 8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0011}, // R10
      '{1'b1, 2'b01, 32'h3FF8, 8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b10, 4'b0000}, // R10
      '{1'b0, 2'b00, 32'h400,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h3000, 2'b10, 4'b0000}, // R14
      '{1'b1, 2'b00, 32'h400,  8'd0, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b10, 4'b0000}, // R14
      '{1'b0, 2'b01, 32'h500,  8'd0, 3'd3, 8'hFF, 4'b0000, 64'h4000, 2'b00, 4'b0000}, // R3
      '{1'b0, 2'b01, 32'h500,  8'd0, 3'd3, 8'h3C, 4'b0000, 64'h5555, 2'b00, 4'b0000}, // R3
      '{1'b1, 2'b01, 32'h500,  8'd0, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}, // R3
      '{1'b0, 2'b01, 32'h100,  8'd1, 3'd3, 8'hFF, 4'b0001, 64'h6000, 2'b00, 4'b0000}, // R4
      '{1'b1, 2'b01, 32'h100,  8'd1, 3'd3, 8'hFF, 4'b0000, 64'h0,    2'b00, 4'b0000}  // R4
   };
   localparam int VREQ [NV] = '{4,4,5,5,5,6,6,7,7,7,8,8,8,8,9,10,10,10,10,10,14,14,3,3,3,4,4};

   logic aclk = 1'b0, aresetn = 1'b0;
   logic [3:0]  awid = '0, arid = '0;
   logic [31:0] awaddr = '0, araddr = '0;
   logic [7:0]  awlen = '0, arlen = '0;
   logic [2:0]  awsize = '0, arsize = '0;
   logic [1:0]  awburst = '0, arburst = '0;
   logic        awvalid = 1'b0, arvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, rready = 1'b0;
   logic [63:0] wdata = '0;
   logic [7:0]  wstrb = '0;
   logic        wlast = 1'b0, wuser = 1'b0;
   logic        awready, wready, arready, bvalid, rvalid, rlast, ruser;
   logic [3:0]  bid, rid;
   logic [1:0]  bresp, rresp;
   logic [63:0] rdata;

   int total = 0, fails = 0, cyc = 0;
   logic [63:0] shadow [int];

   always #2.5 aclk = ~aclk;

   tsram_axi u_tsram_axi (
      .aclk(aclk), .aresetn(aresetn),
      .s_awid(awid), .s_awaddr(awaddr), .s_awlen(awlen), .s_awsize(awsize),
      .s_awburst(awburst), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast), .s_wuser(wuser),
      .s_wvalid(wvalid), .s_wready(wready),
      .s_bid(bid), .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_arid(arid), .s_araddr(araddr), .s_arlen(arlen), .s_arsize(arsize),
      .s_arburst(arburst), .s_arvalid(arvalid), .s_arready(arready),
      .s_rid(rid), .s_rdata(rdata), .s_rresp(rresp), .s_rlast(rlast),
      .s_ruser(ruser), .s_rvalid(rvalid), .s_rready(rready));

   task automatic chk(input bit ok, input int req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_aw(input logic [3:0] id, input logic [31:0] a, input logic [7:0] l,
                          input logic [2:0] s, input logic [1:0] b);
      awid = id; awaddr = a; awlen = l; awsize = s; awburst = b; awvalid = 1'b1;
      while (!awready) @(negedge aclk);
      @(negedge aclk);
      awvalid = 1'b0;
   endtask

   task automatic send_ar(input logic [3:0] id, input logic [31:0] a, input logic [7:0] l,
                          input logic [2:0] s, input logic [1:0] b);
      arid = id; araddr = a; arlen = l; arsize = s; arburst = b; arvalid = 1'b1;
      while (!arready) @(negedge aclk);
      @(negedge aclk);
      arvalid = 1'b0;
   endtask

   task automatic send_w(input logic [63:0] d, input logic [7:0] sb, input logic u, input logic last);
      wdata = d; wstrb = sb; wuser = u; wlast = last; wvalid = 1'b1;
      while (!wready) @(negedge aclk);
      @(negedge aclk);
      wvalid = 1'b0;
   endtask

   task automatic get_b(output logic [3:0] id, output logic [1:0] resp);
      bready = 1'b1;
      while (!bvalid) @(negedge aclk);
      id = bid; resp = bresp;
      @(negedge aclk);
      bready = 1'b0;
   endtask

   task automatic get_r(output logic [63:0] d, output logic u, output logic [1:0] resp,
                        output logic [3:0] id, output logic last);
      rready = 1'b1;
      while (!rvalid) @(negedge aclk);
      d = rdata; u = ruser; resp = rresp; id = rid; last = rlast;
      @(negedge aclk);
      rready = 1'b0;
   endtask

   function automatic void shadow_put(input int w, input logic [63:0] d, input logic [7:0] sb);
      logic [63:0] old;
      old = shadow.exists(w) ? shadow[w] : 64'h0;
      for (int l = 0; l < 8; l++) if (sb[l]) old[l*8 +: 8] = d[l*8 +: 8];
      shadow[w] = old;
   endfunction

   task automatic full_write(input logic [3:0] id, input logic [31:0] a, input logic [63:0] d);
      logic [3:0] gid; logic [1:0] gr;
      send_aw(id, a, 8'd0, 3'd3, 2'b01);
      send_w(d, 8'hFF, 1'b0, 1'b1);
      get_b(gid, gr);
      shadow_put(int'(a >> 3), d, 8'hFF);
   endtask

   always @(posedge aclk) begin
      cyc++;
      if (cyc > 100000) begin
         total++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [3:0] gid; logic [1:0] gr; logic [63:0] gd; logic gu, gl;
      repeat (3) @(negedge aclk);
      // R13: reset state
      chk(awready && wready && arready, 13, {61'b0, awready, wready, arready}, 64'h7);
      chk(!rvalid && !bvalid, 13, {62'b0, rvalid, bvalid}, 64'h0);
      aresetn = 1'b1;
      @(negedge aclk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [3:0] id;
         v = VECS[i];
         id = 4'(i);
         if (!v.op) begin
            send_aw(id, v.addr, v.len, v.size, v.burst);
            for (int b = 0; b <= int'(v.len); b++)
               send_w(v.dat + 64'(b), v.strb, v.usr[b], b == int'(v.len));
            get_b(gid, gr);
            chk(gid == id, 1, 64'(gid), 64'(id));          // R1
            chk(gr == v.xresp, VREQ[i], 64'(gr), 64'(v.xresp));
            if (v.xresp == 2'b00)
               for (int b = 0; b <= int'(v.len); b++)
                  shadow_put(int'(v.addr >> 3) + b, v.dat + 64'(b), v.strb);
         end else begin
            send_ar(id, v.addr, v.len, v.size, v.burst);
            for (int b = 0; b <= int'(v.len); b++) begin
               int w;
               logic [63:0] xd;
               w = int'((v.addr + (32'(b) << v.size)) >> 3);
               xd = (v.xresp != 2'b00) ? 64'h0 : (shadow.exists(w) ? shadow[w] : 64'h0);
               get_r(gd, gu, gr, gid, gl);
               chk(gid == id, 1, 64'(gid), 64'(id));       // R1
               chk(gl == (b == int'(v.len)), 2, 64'(gl), 64'(b == int'(v.len))); // R2
               chk(gr == v.xresp, VREQ[i], 64'(gr), 64'(v.xresp));
               chk(gu == v.xusr[b], VREQ[i], 64'(gu), 64'(v.xusr[b]));
               chk(gd == xd, VREQ[i], gd, xd);
            end
         end
      end

      // R11: write-address FIFO fills while no write data arrives
      send_aw(4'h1, 32'h700, 8'd0, 3'd3, 2'b01);
      send_aw(4'h2, 32'h708, 8'd0, 3'd3, 2'b01);
      send_aw(4'h3, 32'h710, 8'd0, 3'd3, 2'b01);
      chk(!awready, 11, 64'(awready), 64'h0);
      send_w(64'h7001, 8'hFF, 1'b0, 1'b1);
      send_w(64'h7002, 8'hFF, 1'b0, 1'b1);
      send_w(64'h7003, 8'hFF, 1'b0, 1'b1);
      repeat (4) @(negedge aclk);
      // R11: held write response
      chk(bvalid && bid == 4'h1, 11, {59'b0, bvalid, bid}, {59'b0, 1'b1, 4'h1});
      for (int k = 1; k <= 3; k++) begin
         get_b(gid, gr);
         chk(gid == 4'(k) && gr == 2'b00, 11, 64'(gid), 64'(k));
         shadow_put(int'((32'h700 >> 3)) + k - 1, 64'h7000 + 64'(k), 8'hFF);
      end

      // R12: write served before a waiting read
      full_write(4'h4, 32'h608, 64'h1111);
      send_aw(4'h5, 32'h600, 8'd0, 3'd3, 2'b01);
      send_ar(4'h6, 32'h608, 8'd0, 3'd3, 2'b01);
      send_aw(4'h7, 32'h608, 8'd0, 3'd3, 2'b01);
      send_w(64'hCAFE, 8'hFF, 1'b0, 1'b1);
      get_b(gid, gr);
      chk(gid == 4'h5, 12, 64'(gid), 64'h5);
      send_w(64'hD00D, 8'hFF, 1'b0, 1'b1);
      get_b(gid, gr);
      chk(gid == 4'h7, 12, 64'(gid), 64'h7);
      get_r(gd, gu, gr, gid, gl);
      chk(gd == 64'hD00D && gid == 4'h6, 12, gd, 64'hD00D);

      // R13: reset during a read burst
      send_ar(4'h8, 32'h300, 8'd3, 3'd3, 2'b01);
      get_r(gd, gu, gr, gid, gl);
      aresetn = 1'b0;
      repeat (2) @(negedge aclk);
      aresetn = 1'b1;
      @(negedge aclk);
      chk(!rvalid && arready, 13, {62'b0, rvalid, arready}, 64'h1);
      send_ar(4'h9, 32'h500, 8'd0, 3'd3, 2'b01);
      get_r(gd, gu, gr, gid, gl);
      chk(gid == 4'h9 && gr == 2'b00 && gl && gd == shadow[int'(32'h500 >> 3)], 13,
          gd, shadow[int'(32'h500 >> 3)]);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule